// File: doc/BRIEF.md
# Byte-Wide Memory with Signature Space

This block is a clocked model of a byte-wide memory that sits behind an asynchronous, SRAM-style parallel bus. A system clock samples the bus. The bus has active-low chip enable, output enable and write enable, a 15-bit address and a byte of data. The bidirectional data path is split into a data-in byte, a data-out byte and an output-enable flag, and a board-level tri-state buffer is expected to join them. Writes take effect at bus speed. There is no busy state and nothing to poll, so any access may follow a write at once.

A separate select input stands for the high-voltage condition that opens a 64-byte identification area. In that mode six address pins form the index into the area. Two of its entries are fixed identification codes and the other 62 can be written. A write-inhibit input from a supply monitor blocks every write and keeps the data outputs switched off.

The number of storage bits behind the main array is a parameter. The default depth is 2048 bytes and the bus address folds onto it. Setting `ARR_AW` to 15 gives the full 32,768-byte array.

Top module: `nvsm_mem`

## Requirements
- R1: A committed byte is stored at location `addr mod 2^ARR_AW` of the main array. The default `ARR_AW` is 11, so address 0x0805 and address 0x0005 reach the same byte. A later read of that location returns the byte.
- R2: After reset, every main-array byte and every user signature byte reads 0xFF.
- R3: `dout_oe` is high exactly when the bus sample taken two clock edges earlier had `ce_n`=0, `oe_n`=0, `we_n`=1 and `wr_inhibit`=0. The byte on `dout` in that cycle belongs to the same sample.
- R4: A write window is open in every sample with `ce_n`=0 and `we_n`=0, whichever enable fell first. The window closes in the first sample where either enable is high. At the close, the `din` byte of the last sample inside the window is committed.
- R5: When `ce_n`, `oe_n` and `we_n` are all low, the outputs are off (`dout_oe`=0) two edges later.
- R6: A read sampled in the close cycle of a write, and reads sampled after it, return the new byte. A new window may open in the cycle that follows a close.
- R7: If the address or `sig_sel` in any window sample differs from its value when the window opened, the write is dropped. `addr_err` is then high for exactly one cycle, at the second edge after the close sample, which is when the commit would have happened.
- R8: With `sig_sel`=1, the signature index is {addr[7], addr[6], addr[14], addr[13], addr[12], addr[0]}, from MSB to LSB. The other address bits have no effect.
- R9: Signature index 0 reads 0x34 and index 1 reads 0x40. Writes to these two indexes are ignored.
- R10: Signature indexes 2 to 63 hold user bytes. A write in signature mode leaves the main array unchanged.
- R11: While `wr_inhibit` is high in any sample of a window, or in its close sample, the write is dropped. While `wr_inhibit` is high, `dout_oe` is low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (15) | Byte address |
| din | input | DATA_W (8) | Data driven onto the bus by the host |
| sig_sel | input | 1 | Opens the signature area |
| wr_inhibit | input | 1 | Supply-monitor write block |
| dout | output | DATA_W (8) | Read data |
| dout_oe | output | 1 | Output drivers on |
| addr_err | output | 1 | One-cycle pulse when a write is aborted |

## Verification
The assertions assume that the bus pins settle between clock edges and are sampled once per edge. They also assume that `rst_n` stays low long enough for the two-stage input pipeline to flush before any property's two-edge history is used. The bench therefore changes every input only on the falling clock edge, and it holds reset for several cycles before the first access. The random stimulus builds whole transactions. Windows open with either enable falling first, or with both falling together. Address moves and inhibit pulses fall only inside the hold cycle of a window, so each error pulse and each dropped write can be tied to one window.

// File: rtl/nvsm_pkg.sv
`timescale 1ns/1ps
package nvsm_pkg;
   // Width of the signature index and the span of pins it draws from.
   localparam int SIG_IW       = 6;
   localparam int SIG_PIN_SPAN = 15;

   typedef enum logic [1:0] {
      WIN_IDLE  = 2'd0,
      WIN_OPEN  = 2'd1,
      WIN_HOLD  = 2'd2,
      WIN_CLOSE = 2'd3
   } win_phase_e;

   // Signature index, most significant first: A7 A6 A14 A13 A12 A0.
   function automatic logic [SIG_IW-1:0] sig_index(input logic [SIG_PIN_SPAN-1:0] a);
      return {a[7], a[6], a[14], a[13], a[12], a[0]};
   endfunction
endpackage

// File: rtl/nvsm_bus_sync.sv
`timescale 1ns/1ps
module nvsm_bus_sync
   import nvsm_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              sig_sel,
   input  logic              wr_inhibit,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_sig,
   output logic              wr_commit,
   output logic              wr_abort,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_sig,
   output logic [DATA_W-1:0] wr_data
);
   // Sampled bus, active-high enables.
   logic              ce_s, oe_s, we_s, sig_s, inh_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;

   // Window tracking.
   logic              win_q, abort_q, blk_q, win_sig;
   logic [ADDR_W-1:0] win_addr;
   logic [DATA_W-1:0] win_data;

   logic       win_now, moved;
   win_phase_e phase;

   assign win_now = ce_s & we_s;
   assign moved   = {win_sig, win_addr} != {sig_s, addr_s};

   always_comb begin
      if (win_now && !win_q)      phase = WIN_OPEN;
      else if (win_now && win_q)  phase = WIN_HOLD;
      else if (!win_now && win_q) phase = WIN_CLOSE;
      else                        phase = WIN_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_s     <= 1'b0;
         oe_s     <= 1'b0;
         we_s     <= 1'b0;
         sig_s    <= 1'b0;
         inh_s    <= 1'b0;
         addr_s   <= '0;
         din_s    <= '0;
         win_q    <= 1'b0;
         abort_q  <= 1'b0;
         blk_q    <= 1'b0;
         win_sig  <= 1'b0;
         win_addr <= '0;
         win_data <= '0;
      end else begin
         ce_s   <= ~ce_n;
         oe_s   <= ~oe_n;
         we_s   <= ~we_n;
         sig_s  <= sig_sel;
         inh_s  <= wr_inhibit;
         addr_s <= addr;
         din_s  <= din;
         win_q  <= win_now;
         case (phase)
            WIN_OPEN: begin
               win_addr <= addr_s;
               win_sig  <= sig_s;
               win_data <= din_s;
               abort_q  <= 1'b0;
               blk_q    <= inh_s;
            end
            WIN_HOLD: begin
               win_data <= din_s;
               if (moved) abort_q <= 1'b1;
               if (inh_s) blk_q   <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign rd_en     = ce_s & oe_s & ~we_s & ~inh_s;
   assign rd_addr   = addr_s;
   assign rd_sig    = sig_s;
   assign wr_commit = (phase == WIN_CLOSE) & ~abort_q & ~blk_q & ~inh_s;
   assign wr_abort  = (phase == WIN_CLOSE) & abort_q;
   assign wr_addr   = win_addr;
   assign wr_sig    = win_sig;
   assign wr_data   = win_data;
endmodule

// File: rtl/nvsm_array.sv
`timescale 1ns/1ps
module nvsm_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // A byte being committed this cycle is visible to a read in the same cycle.
   assign rdata = (we && (waddr == raddr)) ? wdata : mem[raddr];
endmodule

// File: rtl/nvsm_sig_store.sv
`timescale 1ns/1ps
module nvsm_sig_store #(
   parameter int          IW       = 6,
   parameter int          DW       = 8,
   parameter int          N_FIXED  = 2,
   parameter logic [DW-1:0] MFR_CODE = 8'h34,
   parameter logic [DW-1:0] DEV_CODE = 8'h40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);
   localparam int N = 1 << IW;

   logic [DW-1:0] ent [N];
   logic          w_user;

   assign w_user = we && (int'(widx) >= N_FIXED);

   for (genvar i = 0; i < N; i++) begin : g_ent
      if (i == 0) begin : g_mfr
         assign ent[i] = MFR_CODE;
      end else if (i == 1) begin : g_dev
         assign ent[i] = DEV_CODE;
      end else begin : g_user
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                         q <= '1;
            else if (w_user && (widx == IW'(i))) q <= wdata;
         end
         assign ent[i] = q;
      end
   end

   assign rdata = (w_user && (widx == ridx)) ? wdata : ent[ridx];
endmodule

// File: rtl/nvsm_mem.sv
`timescale 1ns/1ps
module nvsm_mem
   import nvsm_pkg::*;
#(
   parameter int              ADDR_W   = 15,
   parameter int              DATA_W   = 8,
   parameter int              ARR_AW   = 11,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h34,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              sig_sel,
   input  logic              wr_inhibit,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              addr_err
);
   if (ADDR_W < SIG_PIN_SPAN) begin : g_bad_aw
      $error("nvsm_mem: ADDR_W must cover the signature index pins");
   end
   if (ARR_AW < 1 || ARR_AW > ADDR_W) begin : g_bad_arr
      $error("nvsm_mem: ARR_AW must lie in 1..ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("nvsm_mem: DATA_W must be positive");
   end

   logic              rd_en, rd_sig, wr_commit, wr_abort, wr_sig;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] wr_data, arr_rd, sig_rd;
   logic [DATA_W-1:0] dout_q;
   logic              doe_q, err_q;

   nvsm_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
      .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din, .sig_sel, .wr_inhibit,
      .rd_en, .rd_addr, .rd_sig, .wr_commit, .wr_abort, .wr_addr, .wr_sig, .wr_data
   );

   nvsm_array #(.AW(ARR_AW), .DW(DATA_W)) u_array (
      .clk, .rst_n,
      .we    (wr_commit & ~wr_sig),
      .waddr (wr_addr[ARR_AW-1:0]),
      .wdata (wr_data),
      .raddr (rd_addr[ARR_AW-1:0]),
      .rdata (arr_rd)
   );

   nvsm_sig_store #(
      .IW(SIG_IW), .DW(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_sig (
      .clk, .rst_n,
      .we    (wr_commit & wr_sig),
      .widx  (sig_index(wr_addr[SIG_PIN_SPAN-1:0])),
      .wdata (wr_data),
      .ridx  (sig_index(rd_addr[SIG_PIN_SPAN-1:0])),
      .rdata (sig_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q <= '0;
         doe_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         dout_q <= rd_sig ? sig_rd : arr_rd;
         doe_q  <= rd_en;
         err_q  <= wr_abort;
      end
   end

   assign dout     = dout_q;
   assign dout_oe  = doe_q;
   assign addr_err = err_q;
endmodule

// File: rtl/nvsm_chk.sv
`timescale 1ns/1ps
module nvsm_chk
   import nvsm_pkg::*;
#(
   parameter int              ADDR_W   = 15,
   parameter int              DATA_W   = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h34,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              sig_sel,
   input logic              wr_inhibit,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe,
   input logic              addr_err
);
   p_oe_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> ($past(!ce_n, 2) && $past(!oe_n, 2) && $past(we_n, 2) && $past(!wr_inhibit, 2)));

   p_we_blanks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && !we_n) |=> ##1 !dout_oe);

   p_inhibit_blanks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inhibit |=> ##1 !dout_oe);

   p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |=> !addr_err);

   p_mfr_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && $past(sig_sel, 2) && (sig_index($past(addr[SIG_PIN_SPAN-1:0], 2)) == 6'd0))
      |-> (dout == MFR_CODE));

   p_dev_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && $past(sig_sel, 2) && (sig_index($past(addr[SIG_PIN_SPAN-1:0], 2)) == 6'd1))
      |-> (dout == DEV_CODE));
endmodule

bind nvsm_mem nvsm_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
   .sig_sel(sig_sel), .wr_inhibit(wr_inhibit), .dout(dout), .dout_oe(dout_oe),
   .addr_err(addr_err)
);

// File: tb/nvsm_mem_tb.sv
`timescale 1ns/1ps
module nvsm_mem_tb;
   localparam int ADDR_W = 15;
   localparam int DATA_W = 8;
   localparam int ARR_AW = 11;
   localparam int DEPTH  = 1 << ARR_AW;
   localparam logic [7:0] MFR = 8'h34;
   localparam logic [7:0] DEV = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n, ce_n, oe_n, we_n, sig_sel, wr_inhibit;
   logic [14:0] addr;
   logic [7:0]  din;
   logic [7:0]  dout;
   logic        dout_oe, addr_err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [7:0] exp_arr [DEPTH];
   logic [7:0] exp_sig [64];

   always #10 clk = ~clk;   // 50 MHz

   nvsm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_dut (
      .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din, .sig_sel, .wr_inhibit,
      .dout, .dout_oe, .addr_err
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] idx_of(input logic [14:0] a);
      return {a[7], a[6], a[14], a[13], a[12], a[0]};
   endfunction

   function automatic logic [14:0] addr_for_idx(input logic [5:0] i, input logic [14:0] fill);
      logic [14:0] a = fill;
      a[7] = i[5]; a[6] = i[4]; a[14] = i[3]; a[13] = i[2]; a[12] = i[1]; a[0] = i[0];
      return a;
   endfunction

   function automatic logic [7:0] model_rd(input logic [14:0] a, input logic s);
      logic [5:0] k = idx_of(a);
      if (!s)         return exp_arr[a[ARR_AW-1:0]];
      else if (k == 0) return MFR;
      else if (k == 1) return DEV;
      else             return exp_sig[k];
   endfunction

   task automatic model_wr(input logic [14:0] a, input logic s, input logic [7:0] d);
      logic [5:0] k = idx_of(a);
      if (!s)        exp_arr[a[ARR_AW-1:0]] = d;
      else if (k > 1) exp_sig[k] = d;
   endtask

   task automatic idle_bus();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; wr_inhibit = 1'b0;
   endtask

   // order: 0 both enables fall together, 1 chip enable first, 2 write enable first
   task automatic write_op(input logic [14:0] a, input logic s, input logic [7:0] d,
                           input int order, input bit glitch, input bit inh, input string tag);
      addr = a; sig_sel = s; din = ~d; oe_n = 1'b1;
      if (order == 1) begin ce_n = 1'b0; we_n = 1'b1; @(negedge clk); end
      if (order == 2) begin ce_n = 1'b1; we_n = 1'b0; @(negedge clk); end
      ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);                       // open sample
      din = d;
      if (glitch) addr = a ^ 15'h0010;
      wr_inhibit = inh;
      @(negedge clk);                       // hold sample
      wr_inhibit = 1'b0; addr = a;
      if (order == 2) ce_n = 1'b1; else we_n = 1'b1;
      @(negedge clk);                       // close sample
      idle_bus();
      @(negedge clk);
      check({tag, " R7 addr_err"}, addr_err, glitch);
      if (!glitch && !inh) model_wr(a, s, d);
   endtask

   task automatic read_op(input logic [14:0] a, input logic s, input string tag);
      addr = a; sig_sel = s; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check({tag, " R3 dout_oe"}, dout_oe, 1'b1);
      check({tag, " data"}, dout, model_rd(a, s));
      idle_bus();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) exp_arr[i] = 8'hFF;
      for (int i = 0; i < 64; i++)    exp_sig[i] = 8'hFF;
      rst_n = 1'b0; idle_bus(); addr = '0; din = '0; sig_sel = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 reset dout_oe", dout_oe, 1'b0);
      check("R7 reset addr_err", addr_err, 1'b0);

      // R2: erased state
      read_op(15'h0000, 1'b0, "R2 array low");
      read_op(15'h07FF, 1'b0, "R2 array top");
      read_op(addr_for_idx(6'd2, 15'h0000), 1'b1, "R2 sig idx2");
      read_op(addr_for_idx(6'd63, 15'h0F1E), 1'b1, "R2 sig idx63");

      // R9: fixed codes, read-only
      read_op(addr_for_idx(6'd0, 15'h0000), 1'b1, "R9 mfr");
      read_op(addr_for_idx(6'd1, 15'h0aaa), 1'b1, "R9 dev");
      write_op(addr_for_idx(6'd0, 15'h0000), 1'b1, 8'h00, 0, 0, 0, "R9 wr mfr");
      read_op(addr_for_idx(6'd0, 15'h0F3E), 1'b1, "R9 mfr after write");
      write_op(addr_for_idx(6'd1, 15'h0000), 1'b1, 8'h11, 1, 0, 0, "R9 wr dev");
      read_op(addr_for_idx(6'd1, 15'h0000), 1'b1, "R9 dev after write");

      // R8: only the six index pins matter
      write_op(addr_for_idx(6'd37, 15'h0000), 1'b1, 8'hA5, 0, 0, 0, "R8 wr");
      read_op(addr_for_idx(6'd37, 15'h0F3E), 1'b1, "R8 other filler");
      // R10: signature write leaves main array alone
      read_op(addr_for_idx(6'd37, 15'h0000), 1'b0, "R10 array unchanged");

      // R1 and R4: orders, last sampled byte, aliasing
      write_op(15'h0805, 1'b0, 8'h5A, 0, 0, 0, "R4 order0");
      read_op(15'h0005, 1'b0, "R1 alias");
      write_op(15'h0123, 1'b0, 8'hC3, 1, 0, 0, "R4 ce first");
      read_op(15'h0123, 1'b0, "R4 ce first");
      write_op(15'h0456, 1'b0, 8'h81, 2, 0, 0, "R4 we first");
      read_op(15'h0456, 1'b0, "R4 we first");

      // R7: moved address aborts
      write_op(15'h0200, 1'b0, 8'h12, 0, 1, 0, "R7 glitch");
      read_op(15'h0200, 1'b0, "R7 old kept");
      read_op(15'h0210, 1'b0, "R7 moved addr untouched");

      // R11: inhibit blocks writes and reads
      write_op(15'h0300, 1'b0, 8'h77, 0, 0, 1, "R11 inhibited");
      read_op(15'h0300, 1'b0, "R11 not written");
      addr = 15'h0300; sig_sel = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; wr_inhibit = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R11 dout_oe off", dout_oe, 1'b0);
      idle_bus(); @(negedge clk);

      // R3: partial enables
      ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R3 oe high", dout_oe, 1'b0);
      ce_n = 1'b1; oe_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R3 ce high", dout_oe, 1'b0);
      idle_bus(); @(negedge clk);

      // R5: write enable low with outputs enabled
      addr = 15'h0044; din = 8'h3C; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R5 outputs off", dout_oe, 1'b0);
      idle_bus(); @(negedge clk); @(negedge clk);
      model_wr(15'h0044, 1'b0, 8'h3C);
      read_op(15'h0044, 1'b0, "R4 R5 committed");

      // R6: read in the close cycle, then a write right after
      addr = 15'h0666; sig_sel = 1'b0; din = 8'hE7; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
      @(negedge clk); @(negedge clk);
      we_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      model_wr(15'h0666, 1'b0, 8'hE7);
      oe_n = 1'b1; we_n = 1'b0; addr = 15'h0667; din = 8'h19;
      @(negedge clk);
      check("R6 close-cycle read oe", dout_oe, 1'b1);
      check("R6 close-cycle read data", dout, 8'hE7);
      we_n = 1'b1;
      @(negedge clk);
      idle_bus(); @(negedge clk);
      model_wr(15'h0667, 1'b0, 8'h19);
      read_op(15'h0667, 1'b0, "R6 back-to-back write");

      // Random mix
      for (int n = 0; n < 400; n++) begin
         logic [14:0] ra = 15'($urandom);
         logic        rs = ($urandom % 4) == 0;
         if (($urandom % 2) == 0)
            write_op(ra, rs, 8'($urandom), int'($urandom % 3),
                     ($urandom % 8) == 0, ($urandom % 10) == 0, "R1 R10 rand");
         else
            read_op(ra, rs, "R1 R8 rand");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule